// File: doc/BRIEF.md
# Single-Clock 9-Bit FIFO with Half-Full Flag and Rewind

This block is a first-in first-out buffer of 9-bit words on one clock. Its depth is a power of two from 256 to 4096 words and is set by a parameter. A producer pulses a write strobe to push one word per cycle. A consumer pulses a read strobe to pop one word per cycle.

Three active-high status flags are derived from the distance between the read pointer and the write pointer:

- empty,
- full,
- half-full, which sets once more than half of the words are occupied.

Writes while full and reads while empty are dropped. A popped word appears on the registered output one cycle after the strobe, qualified by a one-cycle valid pulse. When the valid pulse is low, the data output is held at zero.

A rewind request sets the read pointer back to storage location zero, so that everything written since reset can be read out again. The request is honoured only while both strobes are idle. A rewind that arrives together with a strobe is dropped, and the block reports it on an error output.

Top module: `fifo9_hf_rt`

## Requirements
- R1: While `mrst` is high, and right after it falls, `empty`=1, `full`=0, `half_full`=0, `rd_valid`=0 and `rd_data`=0.
- R2: Words are read in the order they were written. An accepted read gives `rd_valid`=1 with the word on `rd_data` after the next clock edge. `rd_data` is 0 whenever `rd_valid` is 0. `empty` clears after the first write.
- R3: `half_full` sets on the write that takes the occupancy from DEPTH/2 to DEPTH/2+1. It stays set while the occupancy is above DEPTH/2.
- R4: `half_full` clears on the read that takes the occupancy from DEPTH/2+1 to DEPTH/2.
- R5: `full` sets on the write that makes the occupancy DEPTH. A write while full is dropped: the word is not stored and the write pointer does not move.
- R6: A read while empty is dropped. `rd_valid` stays 0 and the read pointer does not move, so the next word written is the next word read.
- R7: `full` clears after one accepted read. A read and a write in the same cycle while full accept only the read.
- R8: A read and a write in the same cycle while neither empty nor full are both accepted, and the occupancy does not change.
- R9: A rewind pulse with both strobes low moves the read pointer to location 0. All flags are then recomputed from the pointers. For example, after DEPTH writes and DEPTH reads, a rewind gives `full`=1, `half_full`=1 and `empty`=0.
- R10: After a rewind, reads return every word from the first one written up to the write pointer, already-read words included. Words written after the rewind follow in order.
- R11: A rewind pulse in the same cycle as either strobe is dropped. `rewind_err` is 1 for the cycle after it, and the strobes act as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mrst | input | 1 | Synchronous master reset, active high |
| wr_stb | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 9 | Word to write |
| rd_stb | input | 1 | Read strobe, one word per cycle |
| rewind | input | 1 | Rewind request: read pointer to location 0 |
| rd_data | output | 9 | Registered read word, 0 when not valid |
| rd_valid | output | 1 | One-cycle pulse after each accepted read |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| half_full | output | 1 | More than DEPTH/2 words stored |
| rewind_err | output | 1 | A rewind collided with a strobe in the previous cycle |

## Verification
Every result is due exactly one clock edge after the cycle in which its stimulus is sampled. The flags follow the pointer registers, and `rd_data`, `rd_valid` and `rewind_err` are registered. The bench therefore changes inputs on the falling edge, lets one rising edge pass, and samples at the following falling edge before it drives anything new. Boundary cycles are checked exactly at the occupancy where they apply:

- DEPTH/2 and DEPTH/2+1 for half-full,
- DEPTH-1 and DEPTH for full,
- zero for empty.

Dropped strobes are shown to have no effect by reading the whole content back and checking that empty comes after the expected count.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
   localparam int unsigned WORD_W = 9;
   localparam int unsigned MIN_DEPTH = 256;
   localparam int unsigned MAX_DEPTH = 4096;

   typedef logic [WORD_W-1:0] word_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/fifo9_ptr.sv
module fifo9_ptr #(
   parameter int unsigned AW = 8
) (
   input  logic        clk,
   input  logic        mrst,
   input  logic        adv,
   input  logic        to_zero,
   output logic [AW:0] ptr
);
   always_ff @(posedge clk) begin
      if (mrst)
         ptr <= '0;
      else if (to_zero)
         ptr <= '0;
      else if (adv)
         ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/fifo9_flags.sv
module fifo9_flags #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned AW    = 8
) (
   input  logic [AW:0] wptr,
   input  logic [AW:0] rptr,
   output logic [AW:0] occ,
   output logic        empty,
   output logic        full,
   output logic        half_full
);
   localparam logic [AW:0] LVL_FULL = (AW+1)'(DEPTH);
   localparam logic [AW:0] LVL_HALF = (AW+1)'(DEPTH / 2);

   always_comb begin
      occ       = wptr - rptr;
      empty     = (occ == '0);
      full      = (occ == LVL_FULL);
      half_full = (occ > LVL_HALF);
   end
endmodule

// File: rtl/fifo9_store.sv
module fifo9_store
   import fifo9_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned AW    = 8
) (
   input  logic          clk,
   input  logic          mrst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  word_t         wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output word_t         rdata,
   output logic          rvalid
);
   word_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (mrst) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= re;
         rdata  <= re ? mem[raddr] : '0;
      end
   end

   // R2: output is held at zero outside a valid pulse
   assert_idle_zero_R2: assert property (@(posedge clk) disable iff (mrst)
      !rvalid |-> (rdata == '0));
endmodule

// File: rtl/fifo9_hf_rt.sv
module fifo9_hf_rt
   import fifo9_pkg::*;
#(
   parameter int unsigned DEPTH = 256
) (
   input  logic       clk,
   input  logic       mrst,
   input  logic       wr_stb,
   input  logic [8:0] wr_data,
   input  logic       rd_stb,
   input  logic       rewind,
   output logic [8:0] rd_data,
   output logic       rd_valid,
   output logic       empty,
   output logic       full,
   output logic       half_full,
   output logic       rewind_err
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [AW:0] LVL_HALF    = (AW+1)'(DEPTH / 2);
   localparam logic [AW:0] LVL_HALF_P1 = (AW+1)'(DEPTH / 2 + 1);
   localparam logic [AW:0] LVL_FULL_M1 = (AW+1)'(DEPTH - 1);

   if (!is_pow2(DEPTH)) begin : g_bad_pow2
      $error("fifo9_hf_rt: DEPTH must be a power of two");
   end
   if (DEPTH < MIN_DEPTH || DEPTH > MAX_DEPTH) begin : g_bad_range
      $error("fifo9_hf_rt: DEPTH out of supported range");
   end

   logic [AW:0] wptr, rptr, occ;
   logic        wr_acc, rd_acc, rw_ok, rw_bad;

   always_comb begin
      wr_acc = wr_stb && !full;
      rd_acc = rd_stb && !empty;
      rw_bad = rewind && (wr_stb || rd_stb);
      rw_ok  = rewind && !wr_stb && !rd_stb;
   end

   fifo9_ptr #(.AW(AW)) i_wptr (
      .clk(clk), .mrst(mrst), .adv(wr_acc), .to_zero(1'b0), .ptr(wptr)
   );

   fifo9_ptr #(.AW(AW)) i_rptr (
      .clk(clk), .mrst(mrst), .adv(rd_acc), .to_zero(rw_ok), .ptr(rptr)
   );

   fifo9_flags #(.DEPTH(DEPTH), .AW(AW)) i_flags (
      .wptr(wptr), .rptr(rptr), .occ(occ),
      .empty(empty), .full(full), .half_full(half_full)
   );

   fifo9_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
      .clk(clk), .mrst(mrst),
      .we(wr_acc), .waddr(wptr[AW-1:0]), .wdata(wr_data),
      .re(rd_acc), .raddr(rptr[AW-1:0]),
      .rdata(rd_data), .rvalid(rd_valid)
   );

   always_ff @(posedge clk) begin
      if (mrst)
         rewind_err <= 1'b0;
      else
         rewind_err <= rw_bad;
   end

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (mrst)
      $fell(mrst) |-> (empty && !full && !half_full && !rd_valid));

   assert_hf_rise_R3: assert property (@(posedge clk) disable iff (mrst)
      (occ == LVL_HALF) && wr_acc && !rd_acc |=> half_full);

   assert_hf_fall_R4: assert property (@(posedge clk) disable iff (mrst)
      (occ == LVL_HALF_P1) && rd_acc && !wr_acc |=> !half_full);

   assert_full_set_R5: assert property (@(posedge clk) disable iff (mrst)
      (occ == LVL_FULL_M1) && wr_acc && !rd_acc |=> full);

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (mrst)
      full && wr_stb |=> $stable(wptr));

   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (mrst)
      empty && rd_stb |=> (!rd_valid && $stable(rptr)));

   assert_full_clear_R7: assert property (@(posedge clk) disable iff (mrst)
      full && rd_stb |=> !full);

   assert_both_accept_R8: assert property (@(posedge clk) disable iff (mrst)
      !empty && !full && wr_stb && rd_stb |=> ($stable(occ) && rd_valid));

   assert_rewind_zero_R9: assert property (@(posedge clk) disable iff (mrst)
      rw_ok |=> (rptr == '0));

   assert_rewind_err_R11: assert property (@(posedge clk) disable iff (mrst)
      rewind && (wr_stb || rd_stb) |=> rewind_err);
endmodule

// File: tb/test_fifo9_hf_rt.sv
module test_fifo9_hf_rt;
   localparam int DEPTH = 256;
   localparam int HALF  = DEPTH / 2;

   logic       clk = 1'b0;
   logic       mrst = 1'b1;
   logic       wr_stb = 1'b0;
   logic [8:0] wr_data = '0;
   logic       rd_stb = 1'b0;
   logic       rewind = 1'b0;
   logic [8:0] rd_data;
   logic       rd_valid, empty, full, half_full, rewind_err;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   fifo9_hf_rt #(.DEPTH(DEPTH)) i_fifo9_hf_rt (
      .clk(clk), .mrst(mrst), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_stb(rd_stb), .rewind(rewind), .rd_data(rd_data),
      .rd_valid(rd_valid), .empty(empty), .full(full),
      .half_full(half_full), .rewind_err(rewind_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one cycle: drive at a falling edge, pass a rising edge, return at the next falling edge
   task automatic step(input logic w, input logic [8:0] d, input logic r, input logic rw);
      wr_stb = w; wr_data = d; rd_stb = r; rewind = rw;
      @(posedge clk);
      @(negedge clk);
      wr_stb = 1'b0; rd_stb = 1'b0; rewind = 1'b0;
   endtask

   task automatic wr(input logic [8:0] d);
      step(1'b1, d, 1'b0, 1'b0);
   endtask

   task automatic rd_expect(input string req, input logic [8:0] d);
      step(1'b0, '0, 1'b1, 1'b0);
      chk({req, " valid"}, int'(rd_valid), 1);
      chk({req, " data"}, int'(rd_data), int'(d));
   endtask

   task automatic do_reset();
      mrst = 1'b1;
      step(1'b0, '0, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0, 1'b0);
      mrst = 1'b0;
      step(1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 empty", int'(empty), 1);
      chk("R1 full", int'(full), 0);
      chk("R1 half_full", int'(half_full), 0);
      chk("R1 rd_valid", int'(rd_valid), 0);
      chk("R1 rd_data", int'(rd_data), 0);
   endtask

   task automatic t_order();
      do_reset();
      wr(9'h0A5);
      chk("R2 empty clears", int'(empty), 0);
      wr(9'h13C);
      wr(9'h007);
      rd_expect("R2 word0", 9'h0A5);
      step(1'b0, '0, 1'b0, 1'b0);
      chk("R2 idle valid", int'(rd_valid), 0);
      chk("R2 idle data", int'(rd_data), 0);
      rd_expect("R2 word1", 9'h13C);
      rd_expect("R2 word2", 9'h007);
      chk("R2 empty at end", int'(empty), 1);
   endtask

   task automatic t_half();
      do_reset();
      for (int i = 0; i < HALF; i++) wr(9'(i));
      chk("R3 at half", int'(half_full), 0);
      wr(9'h1F0);
      chk("R3 half plus one", int'(half_full), 1);
      for (int i = 0; i < 40; i++) wr(9'(i));
      chk("R3 stays set", int'(half_full), 1);
      for (int i = 0; i < 40; i++) step(1'b0, '0, 1'b1, 1'b0);
      chk("R4 still at half plus one", int'(half_full), 1);
      step(1'b0, '0, 1'b1, 1'b0);
      chk("R4 clears at half", int'(half_full), 0);
   endtask

   task automatic t_full();
      do_reset();
      for (int i = 0; i < DEPTH - 1; i++) wr(9'(i));
      chk("R5 not full at depth-1", int'(full), 0);
      wr(9'(DEPTH - 1));
      chk("R5 full at depth", int'(full), 1);
      wr(9'h1FF);
      chk("R5 full after dropped write", int'(full), 1);
      step(1'b1, 9'h1AA, 1'b1, 1'b0);
      chk("R7 read while full data", int'(rd_data), 0);
      chk("R7 full clears", int'(full), 0);
      for (int i = 1; i < DEPTH; i++) rd_expect("R5 content intact", 9'(i));
      chk("R7 empty after depth-1 reads", int'(empty), 1);
   endtask

   task automatic t_underrun();
      do_reset();
      step(1'b0, '0, 1'b1, 1'b0);
      chk("R6 no valid on empty read", int'(rd_valid), 0);
      step(1'b0, '0, 1'b1, 1'b0);
      chk("R6 still empty", int'(empty), 1);
      wr(9'h042);
      rd_expect("R6 next word", 9'h042);
      chk("R6 empty again", int'(empty), 1);
   endtask

   task automatic t_both();
      do_reset();
      wr(9'h010);
      wr(9'h020);
      step(1'b1, 9'h030, 1'b1, 1'b0);
      chk("R8 read data", int'(rd_data), 9'h010);
      chk("R8 not empty", int'(empty), 0);
      rd_expect("R8 second", 9'h020);
      rd_expect("R8 written in same cycle", 9'h030);
      chk("R8 empty after two", int'(empty), 1);
   endtask

   task automatic t_rewind();
      do_reset();
      for (int i = 0; i < 5; i++) wr(9'h100 + 9'(i));
      for (int i = 0; i < 3; i++) rd_expect("R10 first pass", 9'h100 + 9'(i));
      step(1'b0, '0, 1'b0, 1'b1);
      chk("R9 no error", int'(rewind_err), 0);
      wr(9'h105);
      for (int i = 0; i < 6; i++) rd_expect("R10 replay", 9'h100 + 9'(i));
      chk("R10 empty after replay", int'(empty), 1);
      do_reset();
      for (int i = 0; i < DEPTH; i++) wr(9'(i));
      for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b1, 1'b0);
      chk("R9 drained", int'(empty), 1);
      step(1'b0, '0, 1'b0, 1'b1);
      chk("R9 full recomputed", int'(full), 1);
      chk("R9 half recomputed", int'(half_full), 1);
      chk("R9 empty recomputed", int'(empty), 0);
      rd_expect("R9 first word again", 9'h000);
   endtask

   task automatic t_rewind_err();
      do_reset();
      wr(9'h0C1);
      wr(9'h0C2);
      wr(9'h0C3);
      rd_expect("R11 pre", 9'h0C1);
      step(1'b0, '0, 1'b1, 1'b1);
      chk("R11 err pulse", int'(rewind_err), 1);
      chk("R11 read proceeds", int'(rd_data), 9'h0C2);
      rd_expect("R11 rewind dropped", 9'h0C3);
      chk("R11 err clears", int'(rewind_err), 0);
      chk("R11 empty", int'(empty), 1);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_order();
      t_half();
      t_full();
      t_underrun();
      t_both();
      t_rewind();
      t_rewind_err();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule